// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 32 bits. For each single-word write the host requests, it produces the address, the two active-low strobes that frame the write, the output-enable line and the enable for the controller's tri-state data drivers. Every interval is a whole number of clock cycles: address setup, base write pulse, memory output turn-off, data setup, data hold and write recovery. Each interval is a parameter of at least one cycle.

Two write styles are offered, and a mode input picks one per request. In the write-enable-framed style, chip select goes low first and write enable marks the write. In the chip-select-framed style, write enable goes low first and chip select marks the write. A configuration input can keep output enable low during a write-enable-framed write. When it does, the write pulse is stretched so that the memory has stopped driving before the controller starts. All strobes are registered, so the pins never glitch.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, chip select, write enable and output enable are high, the data drivers are off, `done` is low and `ready` is high.
- R2: A request is taken only on a clock edge where `ready` is high. `ready` stays low from that edge until the write completes, and a request raised while `ready` is low starts no write.
- R3: `done` is high for exactly one cycle. That cycle comes T_AS + P + max(T_DH, T_WR) cycles after the accepting edge, where P is the pulse length of that write. With the default values this is 6 cycles for a plain write and 7 for a stretched one.
- R4: With `mode_cs` = 0 (write enable frames), chip select is low and write enable is high for T_AS cycles. Both are then low for P cycles, and write enable never goes low before chip select.
- R5: With `mode_cs` = 1 (chip select frames), write enable is low and chip select is high for T_AS cycles. Both are then low for P cycles, so chip select never falls before write enable.
- R6: P is max(T_WP, T_DW). When `mode_cs` = 0 and `oe_low` = 1, P is instead the larger of that and T_WHZ + T_DW, and output enable is low for the T_AS + P setup and pulse cycles. In every other case output enable stays high.
- R7: The data drivers are on for the last T_DW cycles of the pulse and the first T_DH cycles after it, for T_DW + T_DH cycles in all. While they are on, the bus carries the captured write data unchanged.
- R8: While either strobe is low, the memory address equals the captured request address, and it does not change while both strobes are low.
- R9: When output enable is low, the drivers switch on no sooner than T_WHZ cycles after write enable fell.
- R10: The address, data, mode and `oe_low` inputs are captured on the accepting edge. Changing them later has no effect on the write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Write request from the host |
| addr | input | 17 | Word address of the request |
| wdata | input | 32 | Write data of the request |
| mode_cs | input | 1 | 0: write enable frames the write, 1: chip select frames it |
| oe_low | input | 1 | Keep output enable low during a write-enable-framed write |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle pulse when write recovery ends |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq | inout | 32 | Memory data bus, driven only while `mem_dq_oe` is high |

## Verification
Each pin is registered once after the accepting edge, so the first setup cycle is visible at the falling edge that follows that edge. A monitor counts falling edges from that point. It expects the overlap to begin at count T_AS, the drivers to switch on at T_AS + P − T_DW, and `done` to appear at T_AS + P + max(T_DH, T_WR). Every pin is sampled on the falling edge, half a cycle from the edge that updates it. The expected item for each write is queued before its accepting edge, and the monitor takes it from the queue in the cycle where `ready` first reads low.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  // Phases of one write transaction
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_POST  = 2'd3
  } wr_phase_t;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_pulse_len.sv
module sram_wr_pulse_len
  import sram_wr_pkg::*;
#(
  parameter int unsigned T_WP  = 3,
  parameter int unsigned T_WHZ = 2,
  parameter int unsigned T_DW  = 2,
  parameter int unsigned CW    = 3
) (
  input  logic          mode_cs,
  input  logic          oe_low,
  output logic          oe_act,
  output logic [CW-1:0] pulse_len,
  output logic [CW-1:0] drv_from
);

  localparam int unsigned P_BASE = imax(T_WP, T_DW);
  localparam int unsigned P_EXT  = imax(P_BASE, T_WHZ + T_DW);

  // Output enable is only held low in the write-enable-framed style
  assign oe_act = !mode_cs && oe_low;

  generate
    if (P_EXT == P_BASE) begin : g_flat
      assign pulse_len = CW'(P_BASE);
    end else begin : g_ext
      assign pulse_len = oe_act ? CW'(P_EXT) : CW'(P_BASE);
    end
  endgenerate

  // Drivers come on so that data is set up T_DW cycles before the rise
  assign drv_from = pulse_len - CW'(T_DW);

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int unsigned T_AS = 1,
  parameter int unsigned T_Q  = 2,
  parameter int unsigned CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] pulse_len,
  output wr_phase_t     phase,
  output wr_phase_t     nxt_phase,
  output logic [CW-1:0] nxt_cnt,
  output logic          done
);

  wr_phase_t     phase_q;
  logic [CW-1:0] cnt_q;
  logic          done_nxt;

  always_comb begin
    nxt_phase = phase_q;
    nxt_cnt   = cnt_q + CW'(1);
    done_nxt  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        nxt_cnt = '0;
        if (start) nxt_phase = PH_SETUP;
      end
      PH_SETUP: begin
        if (cnt_q == CW'(T_AS - 1)) begin
          nxt_phase = PH_PULSE;
          nxt_cnt   = '0;
        end
      end
      PH_PULSE: begin
        if (cnt_q == pulse_len - CW'(1)) begin
          nxt_phase = PH_POST;
          nxt_cnt   = '0;
        end
      end
      PH_POST: begin
        if (cnt_q == CW'(T_Q - 1)) begin
          nxt_phase = PH_IDLE;
          nxt_cnt   = '0;
          done_nxt  = 1'b1;
        end
      end
      default: begin
        nxt_phase = PH_IDLE;
        nxt_cnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      phase_q <= nxt_phase;
      cnt_q   <= nxt_cnt;
      done    <= done_nxt;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int unsigned T_DH = 1,
  parameter int unsigned CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  wr_phase_t     nxt_phase,
  input  logic [CW-1:0] nxt_cnt,
  input  logic          mode_cs,
  input  logic          oe_act,
  input  logic [CW-1:0] drv_from,
  output logic          cs_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          drv_en
);

  logic cs_d, we_d, oe_d, drv_d;

  // Decode the pins from the coming phase so that each pin is a flop
  always_comb begin
    cs_d  = 1'b1;
    we_d  = 1'b1;
    oe_d  = 1'b1;
    drv_d = 1'b0;
    case (nxt_phase)
      PH_SETUP: begin
        // Non-framing strobe goes low first
        cs_d = mode_cs;
        we_d = !mode_cs;
        oe_d = !oe_act;
      end
      PH_PULSE: begin
        cs_d  = 1'b0;
        we_d  = 1'b0;
        oe_d  = !oe_act;
        drv_d = (nxt_cnt >= drv_from);
      end
      PH_POST: begin
        drv_d = (nxt_cnt < CW'(T_DH));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n   <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      drv_en <= 1'b0;
    end else begin
      cs_n   <= cs_d;
      we_n   <= we_d;
      oe_n   <= oe_d;
      drv_en <= drv_d;
    end
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned T_AS   = 1,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_WHZ  = 2,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WR   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mode_cs,
  input  logic              oe_low,
  output logic              ready,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int unsigned T_Q     = imax(T_DH, T_WR);
  localparam int unsigned P_MAX   = imax(imax(T_WP, T_DW), T_WHZ + T_DW);
  localparam int unsigned LEN_MAX = imax(imax(T_AS, P_MAX), T_Q);
  localparam int unsigned CW      = $clog2(LEN_MAX + 1);

  wr_phase_t         phase, nxt_phase;
  logic [CW-1:0]     nxt_cnt, pulse_len, drv_from;
  logic              start, oe_act;
  logic              mode_q, oe_q, mode_nxt, oe_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign ready    = (phase == PH_IDLE);
  assign start    = req && ready;
  assign mode_nxt = start ? mode_cs : mode_q;
  assign oe_nxt   = start ? oe_low  : oe_q;

  // Capture the request; address and data need no reset
  always_ff @(posedge clk) begin
    if (start) begin
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      oe_q   <= oe_nxt;
    end
  end

  sram_wr_pulse_len #(
    .T_WP (T_WP),
    .T_WHZ(T_WHZ),
    .T_DW (T_DW),
    .CW   (CW)
  ) u_len (
    .mode_cs  (mode_nxt),
    .oe_low   (oe_nxt),
    .oe_act   (oe_act),
    .pulse_len(pulse_len),
    .drv_from (drv_from)
  );

  sram_wr_ctrl #(
    .T_AS(T_AS),
    .T_Q (T_Q),
    .CW  (CW)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pulse_len(pulse_len),
    .phase    (phase),
    .nxt_phase(nxt_phase),
    .nxt_cnt  (nxt_cnt),
    .done     (done)
  );

  sram_wr_pins #(
    .T_DH(T_DH),
    .CW  (CW)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .nxt_phase(nxt_phase),
    .nxt_cnt  (nxt_cnt),
    .mode_cs  (mode_nxt),
    .oe_act   (oe_act),
    .drv_from (drv_from),
    .cs_n     (mem_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .drv_en   (mem_dq_oe)
  );

  assign mem_addr = addr_q;
  assign mem_dq   = mem_dq_oe ? data_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned T_WHZ  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [DATA_W-1:0] mem_dq
);

  localparam int unsigned HW = $clog2(T_WHZ + 2);

  // Cycles write enable has been low, saturating at T_WHZ
  logic [HW-1:0] we_low_cnt;
  always_ff @(posedge clk) begin
    if (rst || mem_we_n) we_low_cnt <= '0;
    else if (we_low_cnt != HW'(T_WHZ)) we_low_cnt <= we_low_cnt + HW'(1);
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !done));

  p_take_only_req_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(req));

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_data_steady_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq));

  p_data_round_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs_n) |-> (mem_dq_oe && $past(mem_dq_oe)));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mem_we_n && !$past(mem_cs_n) && !$past(mem_we_n)) |-> $stable(mem_addr));

  p_no_contention_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && !mem_oe_n) |-> (we_low_cnt >= HW'(T_WHZ)));

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .T_WHZ (T_WHZ)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .ready    (ready),
  .done     (done),
  .mem_addr (mem_addr),
  .mem_cs_n (mem_cs_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_oe(mem_dq_oe),
  .mem_dq   (mem_dq)
);

// File: tb/sram_wr_seq_test.sv
module sram_wr_seq_test;

  localparam int AW = 17, DW = 32;
  localparam int TAS = 1, TWP = 3, TWHZ = 2, TDW = 2, TDH = 1, TWR = 2;
  localparam int P_BASE = (TWP > TDW) ? TWP : TDW;
  localparam int P_EXT  = (P_BASE > TWHZ + TDW) ? P_BASE : TWHZ + TDW;
  localparam int TQ     = (TDH > TWR) ? TDH : TWR;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic mode_cs = 1'b0, oe_low = 1'b0;
  wire ready, done, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  wire [AW-1:0] mem_addr;
  wire [DW-1:0] dq;

  always #2 clk = ~clk;

  sram_wr_seq #(
    .ADDR_W(AW), .DATA_W(DW), .T_AS(TAS), .T_WP(TWP), .T_WHZ(TWHZ),
    .T_DW(TDW), .T_DH(TDH), .T_WR(TWR)
  ) uut (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .wdata(wdata),
    .mode_cs(mode_cs), .oe_low(oe_low), .ready(ready), .done(done),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_dq(dq)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    bit m;
    bit o;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_fail = 0, n_push = 0, n_seen = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: queue the expected item, then present the request for one edge
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit m, input bit o);
    item_t it;
    while (!ready) @(negedge clk);
    it.a = a; it.d = d; it.m = m; it.o = o;
    exp_q.push_back(it);
    n_push++;
    addr = a; wdata = d; mode_cs = m; oe_low = o; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    // R10: disturb the inputs while the write runs
    addr = ~a; wdata = ~d; mode_cs = ~m; oe_low = ~o;
  endtask

  // R2: request raised while busy must start nothing
  task automatic poke_busy(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; req = 1'b1;
    repeat (2) @(negedge clk);
    req = 1'b0;
  endtask

  // Monitor: one expected item per observed write
  initial begin : monitor
    bit in_t;
    item_t e;
    int idx, ov, ovs, pre, bad_order, oe_c, drv, drv_first, dbad, abad, plen;
    bit ext;
    in_t = 1'b0;
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (!in_t) begin
        if (done) chk("R3", "done outside a write", 1, 0);
        if (!ready) begin
          in_t = 1'b1; idx = 0; ov = 0; ovs = -1; pre = 0; bad_order = 0;
          oe_c = 0; drv = 0; drv_first = -1; dbad = 0; abad = 0;
          n_seen++;
          if (exp_q.size() == 0) begin
            chk("R2", "write without accepted request", 1, 0);
            e.a = '0; e.d = '0; e.m = 1'b0; e.o = 1'b0;
          end else begin
            e = exp_q.pop_front();
          end
          ext  = !e.m && e.o;
          plen = ext ? P_EXT : P_BASE;
        end
      end
      if (in_t) begin
        if (!mem_cs_n && !mem_we_n) begin
          if (ov == 0) ovs = idx;
          ov++;
        end else if (ov == 0) begin
          if (e.m ? (!mem_we_n && mem_cs_n) : (!mem_cs_n && mem_we_n)) pre++;
          if (e.m ? (!mem_cs_n && mem_we_n) : (!mem_we_n && mem_cs_n)) bad_order++;
        end
        if (!mem_oe_n) oe_c++;
        if (mem_dq_oe) begin
          if (drv == 0) drv_first = idx;
          drv++;
          if (dq !== e.d) dbad++;
        end
        if ((!mem_cs_n || !mem_we_n) && mem_addr !== e.a) abad++;
        if (done) begin
          in_t = 1'b0;
          chk("R3", "done latency", idx, TAS + plen + TQ);
          if (e.m) begin
            chk("R5", "we-low/cs-high lead cycles", pre, TAS);
            chk("R5", "cs low ahead of we", bad_order, 0);
          end else begin
            chk("R4", "cs-low/we-high lead cycles", pre, TAS);
            chk("R4", "we low ahead of cs", bad_order, 0);
          end
          chk("R6", "overlap length", ov, plen);
          chk("R6", "overlap start", ovs, TAS);
          chk("R6", "output enable low cycles", oe_c, ext ? TAS + plen : 0);
          chk("R7", "driver on cycles", drv, TDW + TDH);
          chk("R9", "driver first cycle", drv_first, TAS + plen - TDW);
          chk("R10", "bus data mismatches", dbad, 0);
          chk("R8", "address mismatches", abad, 0);
        end
        idx++;
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state held during reset
    chk("R1", "cs_n in reset", mem_cs_n, 1);
    chk("R1", "we_n in reset", mem_we_n, 1);
    chk("R1", "oe_n in reset", mem_oe_n, 1);
    chk("R1", "driver enable in reset", mem_dq_oe, 0);
    chk("R1", "done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", ready, 1);
    chk("R1", "cs_n after reset", mem_cs_n, 1);

    do_write(17'h1_2345, 32'hDEAD_BEEF, 1'b0, 1'b0);
    do_write(17'h0_0001, 32'h0000_0001, 1'b0, 1'b1);
    poke_busy(17'h0_0BAD, 32'h0BAD_0BAD);
    chk("R2", "ready while busy", ready, 0);
    do_write(17'h1_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    do_write(17'h0_0000, 32'hA5A5_5A5A, 1'b1, 1'b1);
    do_write(17'h0_AAAA, 32'h1234_5678, 1'b0, 1'b1);
    poke_busy(17'h1_5555, 32'h8765_4321);
    do_write(17'h1_5555, 32'h0F0F_F0F0, 1'b1, 1'b0);
    do_write(17'h0_7F00, 32'h8000_0001, 1'b0, 1'b0);

    while (exp_q.size() != 0 || !ready) @(negedge clk);
    repeat (12) @(negedge clk);
    chk("R2", "writes started vs accepted", n_seen, n_push);
    chk("R1", "strobes idle at end", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule